// File: doc/BRIEF.md
# Shared-Pin Control Shift Serializer

This block keeps an 8-bit board control image and copies it into an external serial-in, parallel-out latch register. It uses three lines: a shift clock, a shift data line and a latch strobe. The shift clock and data lines are also wired to a two-wire I2C-style bus, so when an update is done the block must put those two lines back into a pattern from which an I2C master can issue a START.

A host loads a whole image with a write pulse, or changes a single bit with a set or clear pulse. Each of these requests triggers one update. An update sends the byte most significant bit first, one data bit per rising clock edge. The strobe is then pulsed to move the byte to the latch outputs. Finally the block drives clock low, data high and clock high. Every line change is followed by a settling hold of a parameterised number of system clock cycles. If a request arrives during an update, it is remembered and served when the current update ends. The byte sent is always the image as it stood when the update began.

The image bits have these meanings. Bits 0 and 1 select the internal clock for serial ports 0 and 1. Bits 2 and 3 are the active-low DTR lines of those ports. Bit 4 is an extension control and bit 5 is auto-reset. Bit 6 is an active-low PCI reset and bit 7 is an active-low EEPROM write control.

Top module: `ctl_shift_ser`

## Requirements
- R1: After reset, ser_clk_o and ser_dat_o are 1, ser_stb_o is 0 and busy_o is 0. image_o is 0xCC, which puts bits 2, 3, 6 and 7 at their inactive high level. No strobe is issued until a request arrives.
- R2: A wr_pulse_i loads wr_image_i into image_o, visible in the next cycle. busy_o is high in the cycle after the pulse.
- R3: Each update sends exactly 8 data bits, most significant first, each sampled on a rising edge of ser_clk_o. A latch that shifts at each rise and captures at the strobe then holds the image. One more rise, for the idle pattern, ends the update, so there are 9 rises per update.
- R4: ser_dat_o changes only while ser_clk_o is low and was low in the previous cycle. For each bit the order is clock low, then data, then clock high.
- R5: ser_stb_o pulses high exactly once per update, after the eighth data rise. It is high only while busy_o is high, and it changes only while ser_clk_o is high.
- R6: After the strobe the block drives clock low, data high and clock high. When busy_o falls, the lines read clock 1, data 1, strobe 0.
- R7: Every line change is held for SETTLE_CYC system cycles before the next change. The gap between two consecutive changes is never shorter than SETTLE_CYC.
- R8: For an isolated request, busy_o stays high for exactly 29*SETTLE_CYC+1 cycles.
- R9: Requests that arrive while busy are not lost. After the current update, exactly one more update runs with the image as it stands when that update starts.
- R10: bit_set_i sets and bit_clr_i clears image bit bit_idx_i. A clear has priority over a set in the same cycle, and wr_pulse_i has priority over both. Every such pulse requests an update.
- R11: A change to the image during an update does not alter the byte in flight. The changed image is sent by the follow-up update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_pulse_i | input | 1 | Load whole image and request an update |
| wr_image_i | input | IMG_W | Image value for a load |
| bit_set_i | input | 1 | Set one image bit and request an update |
| bit_clr_i | input | 1 | Clear one image bit and request an update |
| bit_idx_i | input | IDX_W | Bit selected by set or clear |
| image_o | output | IMG_W | Current control image |
| busy_o | output | 1 | Update pending or in progress |
| ser_clk_o | output | 1 | Shift clock, shared with the two-wire bus clock |
| ser_dat_o | output | 1 | Shift data, shared with the two-wire bus data |
| ser_stb_o | output | 1 | Latch strobe to the external register |

## Verification
The assertions check the line ordering rules on every cycle. Data may move only while the clock is low, and the strobe may move only while the clock is high and the block is busy. Every line change must respect the settling hold. Whenever busy ends, the lines must sit in the START-ready idle pattern. Only the bench's scenarios can show that the latched byte, read through a latch model, matches the image, and that the busy length is exact. They also show that queued requests coalesce into one follow-up update carrying the newest image, and that a mid-update bit change waits for that follow-up.

// File: rtl/ctl_ser_pkg.sv
package ctl_ser_pkg;

  // Sequencer step encoding: one line change per step
  typedef enum logic [2:0] {
    PH_CLK_LO      = 3'd0,
    PH_DAT         = 3'd1,
    PH_CLK_HI      = 3'd2,
    PH_STB_HI      = 3'd3,
    PH_STB_LO      = 3'd4,
    PH_IDLE_CLK_LO = 3'd5,
    PH_IDLE_DAT_HI = 3'd6,
    PH_IDLE_CLK_HI = 3'd7
  } phase_t;

  // Control image field positions (decoded by the external latch wiring)
  localparam int CTL_SP0_INTCLK = 0;
  localparam int CTL_SP1_INTCLK = 1;
  localparam int CTL_SP0_DTR_N  = 2;
  localparam int CTL_SP1_DTR_N  = 3;
  localparam int CTL_EXT        = 4;
  localparam int CTL_AUTO_RST   = 5;
  localparam int CTL_PCIRST_N   = 6;
  localparam int CTL_EEWC_N     = 7;

  // Inactive levels of the active-low controls
  localparam logic [7:0] CTL_RESET_IMAGE =
    8'((1 << CTL_SP0_DTR_N) | (1 << CTL_SP1_DTR_N) |
       (1 << CTL_PCIRST_N)  | (1 << CTL_EEWC_N));

endpackage

// File: rtl/ctl_image_reg.sv
module ctl_image_reg #(
  parameter int         IMG_W     = 8,
  parameter int         IDX_W     = 3,
  parameter logic [IMG_W-1:0] RST_IMAGE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_pulse,
  input  logic [IMG_W-1:0] wr_data,
  input  logic             set_pulse,
  input  logic             clr_pulse,
  input  logic [IDX_W-1:0] idx,
  output logic [IMG_W-1:0] image_q,
  output logic             upd_req
);

  logic [IMG_W-1:0] onehot;

  always_comb begin
    onehot = '0;
    onehot[idx] = 1'b1;
  end

  // Whole-image load wins; clear wins over set
  always_ff @(posedge clk) begin
    if (rst) begin
      image_q <= RST_IMAGE;
    end else if (wr_pulse) begin
      image_q <= wr_data;
    end else if (clr_pulse) begin
      image_q <= image_q & ~onehot;
    end else if (set_pulse) begin
      image_q <= image_q | onehot;
    end
  end

  assign upd_req = wr_pulse | set_pulse | clr_pulse;

endmodule

// File: rtl/ctl_req_track.sv
module ctl_req_track (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic take,
  output logic pend_q
);

  // A single flag coalesces any number of requests made while busy
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (req) begin
      pend_q <= 1'b1;
    end else if (take) begin
      pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ctl_shift_seq.sv
module ctl_shift_seq
  import ctl_ser_pkg::*;
#(
  parameter int IMG_W      = 8,
  parameter int SETTLE_CYC = 600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IMG_W-1:0] image,
  output logic             take,
  output logic             active_q,
  output logic             clk_q,
  output logic             dat_q,
  output logic             stb_q
);

  localparam int BW = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int TW = $clog2(SETTLE_CYC + 1);
  localparam logic [TW-1:0] T_LOAD   = TW'(SETTLE_CYC - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(IMG_W - 1);

  phase_t           phase_q;
  logic [BW-1:0]    bit_q;
  logic [TW-1:0]    timer_q;
  logic [IMG_W-1:0] sh_q;

  assign take = start & ~active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      phase_q  <= PH_CLK_LO;
      bit_q    <= '0;
      timer_q  <= '0;
      sh_q     <= '0;
      clk_q    <= 1'b1;
      dat_q    <= 1'b1;
      stb_q    <= 1'b0;
    end else if (!active_q) begin
      if (start) begin
        active_q <= 1'b1;
        phase_q  <= PH_CLK_LO;
        bit_q    <= '0;
        sh_q     <= image;
        timer_q  <= T_LOAD;
        clk_q    <= 1'b0;
      end
    end else if (timer_q != '0) begin
      timer_q <= timer_q - 1'b1;
    end else begin
      timer_q <= T_LOAD;
      unique case (phase_q)
        PH_CLK_LO: begin
          dat_q   <= sh_q[IMG_W-1];
          phase_q <= PH_DAT;
        end
        PH_DAT: begin
          clk_q   <= 1'b1;
          phase_q <= PH_CLK_HI;
        end
        PH_CLK_HI: begin
          if (bit_q == LAST_BIT) begin
            stb_q   <= 1'b1;
            phase_q <= PH_STB_HI;
          end else begin
            bit_q   <= bit_q + 1'b1;
            sh_q    <= {sh_q[IMG_W-2:0], 1'b0};
            clk_q   <= 1'b0;
            phase_q <= PH_CLK_LO;
          end
        end
        PH_STB_HI: begin
          stb_q   <= 1'b0;
          phase_q <= PH_STB_LO;
        end
        PH_STB_LO: begin
          clk_q   <= 1'b0;
          phase_q <= PH_IDLE_CLK_LO;
        end
        PH_IDLE_CLK_LO: begin
          dat_q   <= 1'b1;
          phase_q <= PH_IDLE_DAT_HI;
        end
        PH_IDLE_DAT_HI: begin
          clk_q   <= 1'b1;
          phase_q <= PH_IDLE_CLK_HI;
        end
        PH_IDLE_CLK_HI: begin
          active_q <= 1'b0;
        end
        default: begin
          active_q <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ctl_shift_ser.sv
module ctl_shift_ser
  import ctl_ser_pkg::*;
#(
  parameter int IMG_W      = 8,
  parameter int SETTLE_CYC = 600,
  parameter logic [IMG_W-1:0] RST_IMAGE = IMG_W'(CTL_RESET_IMAGE),
  localparam int IDX_W     = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_pulse_i,
  input  logic [IMG_W-1:0] wr_image_i,
  input  logic             bit_set_i,
  input  logic             bit_clr_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  output logic [IMG_W-1:0] image_o,
  output logic             busy_o,
  output logic             ser_clk_o,
  output logic             ser_dat_o,
  output logic             ser_stb_o
);

  logic upd_req;
  logic pend_q;
  logic take;
  logic active_q;

  ctl_image_reg #(
    .IMG_W    (IMG_W),
    .IDX_W    (IDX_W),
    .RST_IMAGE(RST_IMAGE)
  ) u_img (
    .clk      (clk),
    .rst      (rst),
    .wr_pulse (wr_pulse_i),
    .wr_data  (wr_image_i),
    .set_pulse(bit_set_i),
    .clr_pulse(bit_clr_i),
    .idx      (bit_idx_i),
    .image_q  (image_o),
    .upd_req  (upd_req)
  );

  ctl_req_track u_req (
    .clk   (clk),
    .rst   (rst),
    .req   (upd_req),
    .take  (take),
    .pend_q(pend_q)
  );

  ctl_shift_seq #(
    .IMG_W     (IMG_W),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (pend_q),
    .image   (image_o),
    .take    (take),
    .active_q(active_q),
    .clk_q   (ser_clk_o),
    .dat_q   (ser_dat_o),
    .stb_q   (ser_stb_o)
  );

  assign busy_o = pend_q | active_q;

endmodule

// File: rtl/ctl_shift_ser_chk.sv
module ctl_shift_ser_chk #(
  parameter int SETTLE_CYC = 600
) (
  input logic clk,
  input logic rst,
  input logic wr_pulse_i,
  input logic busy_o,
  input logic ser_clk_o,
  input logic ser_dat_o,
  input logic ser_stb_o
);

  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] C_SAT = CW'(SETTLE_CYC);
  localparam logic [CW-1:0] C_MIN = CW'(SETTLE_CYC - 1);

  logic [2:0]    prev_q;
  logic [CW-1:0] gap_q;
  logic [2:0]    lines;

  assign lines = {ser_clk_o, ser_dat_o, ser_stb_o};

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 3'b110;
      gap_q  <= C_SAT;
    end else begin
      prev_q <= lines;
      if (lines != prev_q) gap_q <= '0;
      else if (gap_q != C_SAT) gap_q <= gap_q + 1'b1;
    end
  end

  // R4: data moves only under a low clock
  a_r4_dat_clk_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_dat_o) |-> (!ser_clk_o && !$past(ser_clk_o)));

  // R5: strobe only inside an update
  a_r5_stb_busy: assert property (@(posedge clk) disable iff (rst)
    ser_stb_o |-> busy_o);

  // R5: strobe moves only under a high clock
  a_r5_stb_clk_high: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_stb_o) |-> (ser_clk_o && $past(ser_clk_o)));

  // R6: START-ready idle pattern when busy ends
  a_r6_idle_pattern: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (ser_clk_o && ser_dat_o && !ser_stb_o));

  // R7: settling hold between line changes
  a_r7_settle_hold: assert property (@(posedge clk) disable iff (rst)
    (lines != prev_q) |-> (gap_q >= C_MIN));

  // R2: busy follows a write
  a_r2_busy_after_write: assert property (@(posedge clk) disable iff (rst)
    wr_pulse_i |=> busy_o);

  // R9: a request during an update keeps busy asserted
  a_r9_no_lost_req: assert property (@(posedge clk) disable iff (rst)
    (wr_pulse_i && busy_o) |=> busy_o);

endmodule

bind ctl_shift_ser ctl_shift_ser_chk #(
  .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_pulse_i(wr_pulse_i),
  .busy_o    (busy_o),
  .ser_clk_o (ser_clk_o),
  .ser_dat_o (ser_dat_o),
  .ser_stb_o (ser_stb_o)
);

// File: tb/ctl_shift_ser_tb_top.sv
`timescale 1ns/1ps
module ctl_shift_ser_tb_top;

  localparam int S        = 4;
  localparam int BUSY_EXP = 29 * S + 1;
  localparam int NV       = 8;
  // {op[1:0], idx[2:0], data[7:0], expected image[7:0]}; op 0 write, 1 set, 2 clear
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 3'd0, 8'h5A, 8'h5A},
    {2'd1, 3'd0, 8'h00, 8'h5B},
    {2'd2, 3'd6, 8'h00, 8'h1B},
    {2'd0, 3'd0, 8'h81, 8'h81},
    {2'd2, 3'd7, 8'h00, 8'h01},
    {2'd1, 3'd7, 8'h00, 8'h81},
    {2'd0, 3'd0, 8'h00, 8'h00},
    {2'd1, 3'd3, 8'h00, 8'h08}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_pulse_i = 1'b0;
  logic [7:0] wr_image_i = '0;
  logic       bit_set_i = 1'b0;
  logic       bit_clr_i = 1'b0;
  logic [2:0] bit_idx_i = '0;
  logic [7:0] image_o;
  logic       busy_o;
  logic       ser_clk_o;
  logic       ser_dat_o;
  logic       ser_stb_o;

  always #2.5 clk = ~clk;

  ctl_shift_ser #(.IMG_W(8), .SETTLE_CYC(S)) dut_i (
    .clk(clk), .rst(rst),
    .wr_pulse_i(wr_pulse_i), .wr_image_i(wr_image_i),
    .bit_set_i(bit_set_i), .bit_clr_i(bit_clr_i), .bit_idx_i(bit_idx_i),
    .image_o(image_o), .busy_o(busy_o),
    .ser_clk_o(ser_clk_o), .ser_dat_o(ser_dat_o), .ser_stb_o(ser_stb_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Latch model of the external register
  logic [7:0] shift_m = '0;
  logic [7:0] hist [16];
  int         rises = 0;
  int         stbs  = 0;

  always @(posedge ser_clk_o) begin
    shift_m = {shift_m[6:0], ser_dat_o};
    rises   = rises + 1;
  end

  always @(posedge ser_stb_o) begin
    hist[stbs % 16] = shift_m;
    stbs = stbs + 1;
  end

  // Gap between line changes
  logic [2:0] last_ln = 3'b000;
  logic       have_ln = 1'b0;
  int         cyc = 0;
  int         last_cyc = 0;
  int         min_gap = 1000000;

  always @(negedge clk) begin
    if (!rst) begin
      if ({ser_clk_o, ser_dat_o, ser_stb_o} != last_ln) begin
        if (have_ln && (cyc - last_cyc) < min_gap) min_gap = cyc - last_cyc;
        have_ln  = 1'b1;
        last_cyc = cyc;
      end
      last_ln = {ser_clk_o, ser_dat_o, ser_stb_o};
    end
    cyc = cyc + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic s, input logic c,
                       input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    wr_pulse_i = w; bit_set_i = s; bit_clr_i = c;
    bit_idx_i = idx; wr_image_i = d;
    @(negedge clk);
    wr_pulse_i = 1'b0; bit_set_i = 1'b0; bit_clr_i = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n, r0, s0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 image", image_o, 8'hCC);
    chk("R1 clk", ser_clk_o, 1);
    chk("R1 dat", ser_dat_o, 1);
    chk("R1 stb", ser_stb_o, 0);
    chk("R1 busy", busy_o, 0);
    repeat (10) @(negedge clk);
    chk("R1 no strobe", stbs, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      logic [2:0] ix;
      logic [7:0] dv, ev;
      {op, ix, dv, ev} = VEC[v];
      r0 = rises; s0 = stbs;
      issue(op == 2'd0, op == 2'd1, op == 2'd2, ix, dv);
      chk("R2 busy after request", busy_o, 1);
      chk("R2 R10 image", image_o, ev);
      wait_idle(n);
      chk("R8 busy length", n, BUSY_EXP);
      chk("R5 one strobe", stbs - s0, 1);
      chk("R3 rises per update", rises - r0, 9);
      chk("R3 latched byte", hist[(stbs - 1) % 16], ev);
      chk("R6 idle clk", ser_clk_o, 1);
      chk("R6 idle dat", ser_dat_o, 1);
      chk("R6 idle stb", ser_stb_o, 0);
    end

    // R10 write wins over set
    issue(1'b1, 1'b1, 1'b0, 3'd0, 8'h40);
    chk("R10 write priority", image_o, 8'h40);
    wait_idle(n);
    chk("R10 latched", hist[(stbs - 1) % 16], 8'h40);

    // R10 clear wins over set
    issue(1'b0, 1'b1, 1'b1, 3'd6, 8'h00);
    chk("R10 clear priority", image_o, 8'h00);
    wait_idle(n);
    chk("R10 latched clear", hist[(stbs - 1) % 16], 8'h00);

    // R9 queued requests coalesce into one follow-up update
    s0 = stbs;
    issue(1'b1, 1'b0, 1'b0, 3'd0, 8'hA5);
    repeat (10) @(negedge clk);
    issue(1'b1, 1'b0, 1'b0, 3'd0, 8'h3C);
    issue(1'b1, 1'b0, 1'b0, 3'd0, 8'hC3);
    wait_idle(n);
    chk("R9 strobe count", stbs - s0, 2);
    chk("R9 first byte", hist[s0 % 16], 8'hA5);
    chk("R9 final byte", hist[(s0 + 1) % 16], 8'hC3);
    chk("R9 image", image_o, 8'hC3);

    // R11 mid-update bit change waits for the follow-up
    s0 = stbs;
    issue(1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
    repeat (20) @(negedge clk);
    issue(1'b0, 1'b1, 1'b0, 3'd7, 8'h00);
    wait_idle(n);
    chk("R11 strobe count", stbs - s0, 2);
    chk("R11 in-flight byte", hist[s0 % 16], 8'h00);
    chk("R11 follow-up byte", hist[(s0 + 1) % 16], 8'h80);

    // R7 minimum settling gap
    chk("R7 min gap", min_gap, S);

    summary();
    $finish;
  end

endmodule